// File: doc/BRIEF.md
# Paged switch register MDIO bridge

This block lets a management station reach a 32-bit internal switch register file through 16-bit MDIO register accesses. It takes MDIO transactions that have already been deframed: one transaction per cycle with a strobe, a direction, the PHY address, the register number and the write data. It answers reads with a registered 16-bit response one cycle later. Serial MDIO framing and the switch fabric are not part of it.

A page register sits at PHY 0x1F, register 0x10 and supplies the upper internal address bits. Pseudo-PHYs 0x10 to 0x17 select the next three address bits. Register numbers select a 32-bit word within that group, and their bit 0 picks the low or the high 16-bit half. A write of a 32-bit word takes two half writes. The first half is held in a staging latch. The word is committed to the register file only when the completing half arrives, and which half completes depends on the register.

A read of the low half takes a snapshot of the whole word, so that a following read of the high half returns the matching upper bits. One identification word is answered by the bridge itself.

Top module: `swreg_mdio_bridge`

## Requirements
- R1: A write to PHY 0x1F, register 0x10 loads the page register from write data bits [PAGE_W-1:0]. A read at that address returns the page, zero-extended. The page resets to 0 and changes on no other access.
- R2: For PHY 0x10 to 0x17, the internal byte address is {page, PHY[2:0], REG[4:1], 2'b00}. REG[0] selects the half: 0 is bits [15:0] and 1 is bits [31:16].
- R3: For every address except LOW_FIRST_ADDR (0x98), a high-half write is staged. A following low-half write to the same address gives a one-cycle reg_wr_en pulse in the next cycle, carrying that address and data {staged high, new low}.
- R4: For address 0x98 the order is reversed. The low half is staged, and a following high-half write to 0x98 commits {new high, staged low}.
- R5: A completing half with no staged half for the same address, including one that follows a half staged for another address, issues no write and clears the staging latch.
- R6: A read at a data PHY drives reg_rd_en and reg_rd_addr in the same cycle as the request, unless the snapshot of R7 serves it. One cycle later mdio_rvalid is high, and mdio_rdata holds bits [15:0] of the word for half 0.
- R7: A low-half read snapshots the full word. A high-half read of the same address that follows it returns the snapshot's bits [31:16], even if the register file has changed in between. This uses up the snapshot, so a later high-half read fetches again.
- R8: Address 0x10C reads as 0x18007FFF whatever reg_rd_data holds. Writes to it never produce reg_wr_en.
- R9: Accesses to PHYs other than 0x10 to 0x17 and the page address produce no write and leave the staging latch untouched. Reads of them return 0 with mdio_rvalid.
- R10: After reset, mdio_rvalid, reg_wr_en and reg_rd_en are low and no half is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_valid | input | 1 | One MDIO transaction this cycle |
| mdio_write | input | 1 | 1 = write, 0 = read |
| mdio_phy | input | 5 | PHY address of the transaction |
| mdio_reg | input | 5 | Register number of the transaction |
| mdio_wdata | input | 16 | Write data |
| mdio_rvalid | output | 1 | Read response valid, one cycle after the request |
| mdio_rdata | output | 16 | Read response data |
| reg_rd_en | output | 1 | Internal word read strobe (combinational) |
| reg_rd_addr | output | PAGE_W+9 | Internal read byte address |
| reg_rd_data | input | 32 | Internal read data, valid in the same cycle as reg_rd_en |
| reg_wr_en | output | 1 | Internal word write pulse |
| reg_wr_addr | output | PAGE_W+9 | Internal write byte address |
| reg_wr_data | output | 32 | Internal write data |

## Verification
The hardest cases to reach are the ones where the ordering fails. Examples are a completing half that arrives first, at 0x98 or after a half staged for a different word, and a high-half read whose word changes between the two reads. The bench produces these with deliberate half sequences. It changes its register-file model between the two halves of a read, so a stale snapshot and a fresh fetch give different answers. Around this, it sweeps every word of three pages, including the last page, through write, readback and address formation.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_PAGE = 2'd1,
        ACC_DATA = 2'd2
    } acc_kind_e;

    localparam logic [4:0] PAGE_PHY    = 5'h1F;
    localparam logic [4:0] PAGE_REG    = 5'h10;
    localparam logic [1:0] DATA_PHY_HI = 2'b10;
endpackage

// File: rtl/swreg_addr_decode.sv
module swreg_addr_decode #(
    parameter int PAGE_W = 9,
    localparam int ADDR_W = PAGE_W + 9
) (
    input  logic [4:0]              phy,
    input  logic [4:0]              regn,
    input  logic [PAGE_W-1:0]       page,
    output swreg_pkg::acc_kind_e    kind,
    output logic                    half,
    output logic [ADDR_W-1:0]       addr
);
    import swreg_pkg::*;

    always_comb begin
        if (phy == PAGE_PHY && regn == PAGE_REG) begin
            kind = ACC_PAGE;
        end else if (phy[4:3] == DATA_PHY_HI) begin
            kind = ACC_DATA;
        end else begin
            kind = ACC_NONE;
        end
        half = regn[0];
        addr = {page, phy[2:0], regn[4:1], 2'b00};
    end
endmodule

// File: rtl/swreg_wr_stage.sv
module swreg_wr_stage #(
    parameter int ADDR_W = 18,
    parameter logic [ADDR_W-1:0] LOW_FIRST_ADDR = 'h98,
    parameter logic [ADDR_W-1:0] ID_ADDR = 'h10C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_half,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [31:0]       commit_data
);
    typedef struct packed {
        logic              stg_vld;
        logic [ADDR_W-1:0] stg_addr;
        logic [15:0]       stg_data;
        logic              cmt_en;
        logic [ADDR_W-1:0] cmt_addr;
        logic [31:0]       cmt_data;
    } stage_t;

    stage_t st_d, st_q;
    logic   low_first;
    logic   first_half;

    always_comb begin
        st_d        = st_q;
        st_d.cmt_en = 1'b0;
        low_first   = (wr_addr == LOW_FIRST_ADDR);
        first_half  = ~low_first;
        if (wr_req) begin
            if (wr_half == first_half) begin
                st_d.stg_vld  = 1'b1;
                st_d.stg_addr = wr_addr;
                st_d.stg_data = wr_data;
            end else begin
                if (st_q.stg_vld && st_q.stg_addr == wr_addr && wr_addr != ID_ADDR) begin
                    st_d.cmt_en   = 1'b1;
                    st_d.cmt_addr = wr_addr;
                    st_d.cmt_data = low_first ? {wr_data, st_q.stg_data}
                                              : {st_q.stg_data, wr_data};
                end
                st_d.stg_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_en   = st_q.cmt_en;
    assign commit_addr = st_q.cmt_addr;
    assign commit_data = st_q.cmt_data;
endmodule

// File: rtl/swreg_rd_snap.sv
module swreg_rd_snap #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              rd_half,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       word_in,
    output logic              fetch,
    output logic [15:0]       half_out
);
    typedef struct packed {
        logic              snap_vld;
        logic [ADDR_W-1:0] snap_addr;
        logic [31:0]       snap_data;
    } snap_t;

    snap_t sn_d, sn_q;
    logic  hit;

    always_comb begin
        sn_d     = sn_q;
        hit      = rd_req && rd_half && sn_q.snap_vld && (sn_q.snap_addr == rd_addr);
        fetch    = rd_req && !hit;
        if (hit) begin
            half_out = sn_q.snap_data[31:16];
        end else if (rd_half) begin
            half_out = word_in[31:16];
        end else begin
            half_out = word_in[15:0];
        end
        if (rd_req) begin
            if (!rd_half) begin
                sn_d.snap_vld  = 1'b1;
                sn_d.snap_addr = rd_addr;
                sn_d.snap_data = word_in;
            end else begin
                sn_d.snap_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sn_q <= '0;
        end else begin
            sn_q <= sn_d;
        end
    end
endmodule

// File: rtl/swreg_mdio_bridge.sv
module swreg_mdio_bridge #(
    parameter int PAGE_W = 9,
    parameter logic [PAGE_W+8:0] LOW_FIRST_ADDR = 'h98,
    parameter logic [PAGE_W+8:0] ID_ADDR = 'h10C,
    parameter logic [31:0] ID_VALUE = 32'h1800_7FFF,
    localparam int ADDR_W = PAGE_W + 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_valid,
    input  logic              mdio_write,
    input  logic [4:0]        mdio_phy,
    input  logic [4:0]        mdio_reg,
    input  logic [15:0]       mdio_wdata,
    output logic              mdio_rvalid,
    output logic [15:0]       mdio_rdata,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [31:0]       reg_rd_data,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [31:0]       reg_wr_data
);
    import swreg_pkg::*;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              rvalid;
        logic [15:0]       rdata;
    } top_t;

    top_t              tp_d, tp_q;
    acc_kind_e         dec_kind;
    logic              dec_half;
    logic [ADDR_W-1:0] dec_addr;
    logic [31:0]       word_in;
    logic [15:0]       snap_half;
    logic              wr_req;
    logic              rd_req;
    logic [PAGE_W-1:0] page_q;

    assign page_q = tp_q.page;

    swreg_addr_decode #(.PAGE_W(PAGE_W)) decode_i (
        .phy  (mdio_phy),
        .regn (mdio_reg),
        .page (tp_q.page),
        .kind (dec_kind),
        .half (dec_half),
        .addr (dec_addr)
    );

    assign wr_req  = mdio_valid && mdio_write && (dec_kind == ACC_DATA);
    assign rd_req  = mdio_valid && !mdio_write && (dec_kind == ACC_DATA);
    assign word_in = (dec_addr == ID_ADDR) ? ID_VALUE : reg_rd_data;

    swreg_wr_stage #(
        .ADDR_W         (ADDR_W),
        .LOW_FIRST_ADDR (LOW_FIRST_ADDR),
        .ID_ADDR        (ID_ADDR)
    ) stage_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .wr_half     (dec_half),
        .wr_addr     (dec_addr),
        .wr_data     (mdio_wdata),
        .commit_en   (reg_wr_en),
        .commit_addr (reg_wr_addr),
        .commit_data (reg_wr_data)
    );

    swreg_rd_snap #(.ADDR_W(ADDR_W)) snap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_half  (dec_half),
        .rd_addr  (dec_addr),
        .word_in  (word_in),
        .fetch    (reg_rd_en),
        .half_out (snap_half)
    );

    assign reg_rd_addr = dec_addr;

    always_comb begin
        tp_d        = tp_q;
        tp_d.rvalid = mdio_valid && !mdio_write;
        if (mdio_valid && mdio_write && dec_kind == ACC_PAGE) begin
            tp_d.page = mdio_wdata[PAGE_W-1:0];
        end
        if (mdio_valid && !mdio_write) begin
            case (dec_kind)
                ACC_PAGE: tp_d.rdata = 16'(tp_q.page);
                ACC_DATA: tp_d.rdata = snap_half;
                default:  tp_d.rdata = 16'h0000;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tp_q <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    assign mdio_rvalid = tp_q.rvalid;
    assign mdio_rdata  = tp_q.rdata;
endmodule

// File: rtl/swreg_mdio_bridge_chk.sv
module swreg_mdio_bridge_chk #(
    parameter int ADDR_W = 18,
    parameter int PAGE_W = 9,
    parameter logic [ADDR_W-1:0] ID_ADDR = 'h10C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdio_valid,
    input logic              mdio_write,
    input logic [4:0]        mdio_phy,
    input logic [4:0]        mdio_reg,
    input logic              mdio_rvalid,
    input logic              reg_rd_en,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_wr_addr,
    input logic [PAGE_W-1:0] page_q
);
    a_r1_page_only_on_page_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(mdio_valid && mdio_write && mdio_phy == 5'h1F && mdio_reg == 5'h10) |=> $stable(page_q));

    a_r3_write_needs_mdio_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(mdio_valid && mdio_write));

    a_r5_no_back_to_back_commit: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    a_r6_response_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_rvalid |-> $past(mdio_valid && !mdio_write));

    a_r6_fetch_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> (mdio_valid && !mdio_write));

    a_r8_id_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_wr_addr != ID_ADDR));
endmodule

bind swreg_mdio_bridge swreg_mdio_bridge_chk #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .ID_ADDR (ID_ADDR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mdio_valid  (mdio_valid),
    .mdio_write  (mdio_write),
    .mdio_phy    (mdio_phy),
    .mdio_reg    (mdio_reg),
    .mdio_rvalid (mdio_rvalid),
    .reg_rd_en   (reg_rd_en),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .page_q      (page_q)
);

// File: tb/swreg_mdio_bridge_tb_top.sv
`timescale 1ns/1ps
module swreg_mdio_bridge_tb_top;
    localparam int PAGE_W = 9;
    localparam int ADDR_W = PAGE_W + 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mdio_valid = 1'b0;
    logic              mdio_write = 1'b0;
    logic [4:0]        mdio_phy = '0;
    logic [4:0]        mdio_reg = '0;
    logic [15:0]       mdio_wdata = '0;
    logic              mdio_rvalid;
    logic [15:0]       mdio_rdata;
    logic              reg_rd_en;
    logic [ADDR_W-1:0] reg_rd_addr;
    logic [31:0]       reg_rd_data;
    logic              reg_wr_en;
    logic [ADDR_W-1:0] reg_wr_addr;
    logic [31:0]       reg_wr_data;

    int n_chk = 0;
    int n_fail = 0;
    int gen = 0;
    logic [31:0] mem [int];

    always #4 clk = ~clk;

    swreg_mdio_bridge #(.PAGE_W(PAGE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .mdio_valid(mdio_valid), .mdio_write(mdio_write),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_rvalid(mdio_rvalid), .mdio_rdata(mdio_rdata),
        .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
    );

    function automatic logic [31:0] model_word(input logic [ADDR_W-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    always @(reg_rd_addr, gen) reg_rd_data = model_word(reg_rd_addr);

    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[int'(reg_wr_addr)] = reg_wr_data;
            gen = gen + 1;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        @(negedge clk);
        mdio_valid = 1'b1; mdio_write = 1'b1;
        mdio_phy = phy; mdio_reg = rg; mdio_wdata = d;
        @(negedge clk);
        mdio_valid = 1'b0; mdio_write = 1'b0;
    endtask

    task automatic do_rd(input logic [4:0] phy, input logic [4:0] rg, output logic [15:0] r, output logic v);
        @(negedge clk);
        mdio_valid = 1'b1; mdio_write = 1'b0;
        mdio_phy = phy; mdio_reg = rg;
        @(negedge clk);
        mdio_valid = 1'b0;
        r = mdio_rdata; v = mdio_rvalid;
    endtask

    function automatic logic [4:0] phy_of(input logic [ADDR_W-1:0] a);
        return 5'h10 | {2'b00, a[8:6]};
    endfunction

    function automatic logic [4:0] reg_of(input logic [ADDR_W-1:0] a, input logic h);
        return {a[5:2], h};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [15:0] r;
        logic v;
        logic [31:0] old;
        logic [ADDR_W-1:0] a;
        logic [31:0] dat;
        logic [PAGE_W-1:0] pages [3];
        pages[0] = '0; pages[1] = 9'd1; pages[2] = 9'h1FF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(!mdio_rvalid && !reg_wr_en && !reg_rd_en, "R10", {29'd0, mdio_rvalid, reg_wr_en, reg_rd_en}, 32'd0);
        rst_n = 1'b1;
        do_rd(5'h1F, 5'h10, r, v);
        chk(v && r == 16'h0, "R10 page after reset", {15'd0, v, r}, {15'd0, 1'b1, 16'h0});

        // R1 R2 R3 R6 R7: sweep of three pages
        for (int p = 0; p < 3; p++) begin
            do_wr(5'h1F, 5'h10, {7'h55, pages[p]});
            do_rd(5'h1F, 5'h10, r, v);
            chk(v && r == 16'(pages[p]), "R1 page readback", {15'd0, v, r}, {15'd0, 1'b1, 16'(pages[p])});
            for (int w = 0; w < 128; w++) begin
                a = {pages[p], 7'(w), 2'b00};
                if (a == 'h98 || a == 'h10C) continue;
                dat = {a[15:0] ^ 16'hC35A, a[17:2] ^ 16'h0F1E};
                do_wr(phy_of(a), reg_of(a, 1'b1), dat[31:16]);
                chk(!reg_wr_en, "R3 staged half no write", {31'd0, reg_wr_en}, 32'd0);
                do_wr(phy_of(a), reg_of(a, 1'b0), dat[15:0]);
                chk(reg_wr_en && reg_wr_addr == a && reg_wr_data == dat, "R2 R3 commit",
                    reg_wr_data ^ 32'(reg_wr_addr) ^ {31'd0, !reg_wr_en}, dat ^ 32'(a));
                do_rd(phy_of(a), reg_of(a, 1'b0), r, v);
                chk(v && r == dat[15:0], "R6 low half read", {15'd0, v, r}, {15'd0, 1'b1, dat[15:0]});
                do_rd(phy_of(a), reg_of(a, 1'b1), r, v);
                chk(v && r == dat[31:16], "R7 high half read", {15'd0, v, r}, {15'd0, 1'b1, dat[31:16]});
            end
        end

        do_wr(5'h1F, 5'h10, 16'h0000);

        // R4: low-first register 0x98 (PHY 0x12, REG 0x0C/0x0D)
        do_wr(5'h12, 5'h0C, 16'h5678);
        chk(!reg_wr_en, "R4 low staged", {31'd0, reg_wr_en}, 32'd0);
        do_wr(5'h12, 5'h0D, 16'h1234);
        chk(reg_wr_en && reg_wr_addr == 'h98 && reg_wr_data == 32'h1234_5678, "R4 commit on high",
            reg_wr_data, 32'h1234_5678);
        do_wr(5'h12, 5'h0D, 16'hAAAA);
        chk(!reg_wr_en, "R5 high first at 0x98 discarded", {31'd0, reg_wr_en}, 32'd0);
        do_wr(5'h12, 5'h0C, 16'h5555);
        chk(!reg_wr_en, "R4 low staged again", {31'd0, reg_wr_en}, 32'd0);
        do_wr(5'h12, 5'h0D, 16'hBBBB);
        chk(reg_wr_en && reg_wr_data == 32'hBBBB_5555, "R4 second commit", reg_wr_data, 32'hBBBB_5555);

        // R5: mismatch of address (0x40 is PHY 0x11 REG 0x00/0x01, 0x44 is REG 0x02)
        do_wr(5'h11, 5'h01, 16'h1111);
        do_wr(5'h11, 5'h02, 16'h2222);
        chk(!reg_wr_en, "R5 other address discarded", {31'd0, reg_wr_en}, 32'd0);
        do_wr(5'h11, 5'h00, 16'h3333);
        chk(!reg_wr_en, "R5 stage cleared by discard", {31'd0, reg_wr_en}, 32'd0);

        // R9: foreign PHY between halves leaves stage intact
        do_wr(5'h11, 5'h01, 16'h7777);
        do_wr(5'h05, 5'h00, 16'hFFFF);
        chk(!reg_wr_en, "R9 foreign write ignored", {31'd0, reg_wr_en}, 32'd0);
        do_wr(5'h11, 5'h00, 16'h8888);
        chk(reg_wr_en && reg_wr_addr == 'h40 && reg_wr_data == 32'h7777_8888, "R9 stage kept",
            reg_wr_data, 32'h7777_8888);
        do_rd(5'h05, 5'h00, r, v);
        chk(v && r == 16'h0, "R9 foreign read zero", {15'd0, v, r}, {15'd0, 1'b1, 16'h0});

        // R8: identification word 0x10C (PHY 0x14, REG 0x06/0x07)
        do_rd(5'h14, 5'h06, r, v);
        chk(v && r == 16'h7FFF, "R8 id low", {16'd0, r}, 32'h7FFF);
        do_rd(5'h14, 5'h07, r, v);
        chk(v && r == 16'h1800, "R8 id high", {16'd0, r}, 32'h1800);
        do_wr(5'h14, 5'h07, 16'h1234);
        do_wr(5'h14, 5'h06, 16'h5678);
        chk(!reg_wr_en, "R8 id write dropped", {31'd0, reg_wr_en}, 32'd0);

        // R7: snapshot survives a register file change
        a = 'h40;
        do_rd(5'h11, 5'h00, r, v);
        old = model_word(a);
        chk(v && r == old[15:0], "R6 snapshot low", {16'd0, r}, {16'd0, old[15:0]});
        mem[int'(a)] = 32'hDEAD_BEEF;
        gen = gen + 1;
        do_rd(5'h11, 5'h01, r, v);
        chk(v && r == old[31:16], "R7 snapshot high", {16'd0, r}, {16'd0, old[31:16]});
        do_rd(5'h11, 5'h01, r, v);
        chk(v && r == 16'hDEAD, "R7 fresh high after use", {16'd0, r}, 32'hDEAD);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule